// File: doc/BRIEF.md
# Pulse-per-second output generator

This block produces a square-wave timing output from the nanosecond field of a free-running time counter that wraps every second. The block does not divide a fixed frequency. It schedules every edge with a compare threshold held in 32.32 fixed point, where the upper 32 bits are whole nanoseconds and the lower 32 bits are a binary fraction. When the counter reaches the threshold, the output level toggles. The threshold then advances by the interval that belongs to the level just entered: the high interval after a rising internal level and the low interval after a falling one. The sum wraps modulo one second.

A wrapped threshold is numerically smaller than the late-second counter values still to come. For that reason the compare stays closed after a wrap until the counter's rollover strobe is seen. The compare is open again in the rollover cycle itself, so an edge placed exactly on the one-second boundary (threshold 0) still fires. Software sets the enable and inversion controls and writes the two intervals and the threshold. Setting both intervals to 500,000,000 ns gives a 1 Hz output at 50% duty.

Top module: `pps_gen`

## Requirements
- R1: After reset the output is 0, the internal level is low, the output is disabled, and the threshold and both intervals are 0.
- R2: While the enable is 0, the output equals the inversion control and does not toggle, whatever the counter and threshold do.
- R3: While enabled, if the compare is open and the counter's nanosecond value is greater than or equal to the upper 32 bits of the threshold, the internal level toggles at that clock edge. The output is the internal level XOR the inversion control (level high = 1).
- R4: On a toggle to high the threshold advances by the high interval; on a toggle to low it advances by the low interval. The addition is full 64-bit 32.32, so fractions carry into whole nanoseconds.
- R5: If the advanced threshold's nanosecond part is 10^9 or more, 10^9 ns is subtracted and the compare closes. It stays closed until a cycle with the rollover strobe high, and it is open in that cycle. Intervals are below 10^9 ns.
- R6: A threshold that wraps to exactly 0 produces an edge in the rollover cycle in which the counter reads 0.
- R7: At most one toggle occurs per clock cycle, even when the counter is beyond several thresholds at once.
- R8: A threshold write loads all 64 bits, opens the compare, and suppresses a toggle in that cycle. Control and interval writes take effect from the next cycle on.
- R9: Clearing the enable returns the internal level to low, so that after re-enabling, the first edge moves the level to high.
- R10: With both intervals at 500,000,000 ns, the output spends half of each second high and half low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the enable and inversion controls |
| cfg_en | input | 1 | Enable value written on cfg_wr |
| cfg_inv | input | 1 | Inversion value written on cfg_wr |
| hi_inc_wr | input | 1 | Write strobe for the high interval |
| lo_inc_wr | input | 1 | Write strobe for the low interval |
| thr_wr | input | 1 | Write strobe for the threshold |
| reg_wdata | input | 64 | 32.32 value for interval and threshold writes |
| cur_ns | input | 32 | Nanosecond value of the time counter |
| sec_roll | input | 1 | High in the cycle in which cur_ns has just wrapped to the new second |
| pps_out | output | 1 | Pulse output |

## Verification
The bench places a threshold that wraps exactly onto the second boundary. A design that does not close the compare after the wrap would toggle at once on the late-second counter values; a design that ignores the rollover cycle would miss the boundary edge entirely. It also stalls the counter far past a chain of 1 ns thresholds. A design that allowed more than one toggle per cycle, or that skipped ahead, would break the strict alternation the bench expects. Fractional intervals check the carry from the fraction field, because truncating it makes edges drift one nanosecond early. Sequences that disable and then re-enable the output check the idle level after inversion and the return of the internal level to low.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int NS_W = 32;
    localparam int FR_W = 32;
    localparam int FX_W = NS_W + FR_W;
    localparam int N_INC = 2;

    typedef logic [FX_W-1:0] fx_t;
    typedef logic [NS_W-1:0] ns_t;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    typedef struct packed {
        logic en;
        logic inv;
    } ctl_t;

    typedef struct packed {
        logic wrapped;
        fx_t  val;
    } adv_t;

    // Add an interval to a threshold and fold it back into one second.
    function automatic adv_t fx_advance(fx_t base, fx_t inc, ns_t sec_ns);
        logic [FX_W:0] sum;
        logic [FX_W:0] sec_fx;
        adv_t r;
        sum    = {1'b0, base} + {1'b0, inc};
        sec_fx = {1'b0, sec_ns, {FR_W{1'b0}}};
        if (sum >= sec_fx) begin
            r.wrapped = 1'b1;
            sum       = sum - sec_fx;
        end else begin
            r.wrapped = 1'b0;
        end
        r.val = sum[FX_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/pps_ctl_regs.sv
module pps_ctl_regs
    import pps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic                  cfg_en,
    input  logic                  cfg_inv,
    input  logic [N_INC-1:0]      inc_wr,
    input  fx_t                   reg_wdata,
    output ctl_t                  ctl_q,
    output fx_t [N_INC-1:0]       inc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (cfg_wr) begin
            ctl_q.en  <= cfg_en;
            ctl_q.inv <= cfg_inv;
        end
    end

    // index 0: low interval, index 1: high interval (matches lvl_e)
    for (genvar g = 0; g < N_INC; g++) begin : g_inc
        always_ff @(posedge clk) begin
            if (rst) begin
                inc_q[g] <= '0;
            end else if (inc_wr[g]) begin
                inc_q[g] <= reg_wdata;
            end
        end
    end
endmodule

// File: rtl/pps_edge_sched.sv
module pps_edge_sched
    import pps_pkg::*;
#(
    parameter ns_t SEC_NS = 32'd1_000_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl_q,
    input  fx_t [N_INC-1:0]  inc_q,
    input  logic             thr_wr,
    input  fx_t              reg_wdata,
    input  ns_t              cur_ns,
    input  logic             sec_roll,
    output lvl_e             lvl_q
);
    fx_t  thr_q;
    logic wait_q;
    lvl_e nxt_lvl;
    adv_t adv;
    logic cmp_open;
    logic reach;
    logic fire;
    ns_t  thr_ns;

    assign thr_ns   = thr_q[FX_W-1:FR_W];
    assign cmp_open = !wait_q || sec_roll;
    assign reach    = cur_ns >= thr_ns;
    assign fire     = ctl_q.en && !thr_wr && cmp_open && reach;
    assign nxt_lvl  = (lvl_q == LVL_LOW) ? LVL_HIGH : LVL_LOW;
    assign adv      = fx_advance(thr_q, inc_q[nxt_lvl], SEC_NS);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= '0;
            wait_q <= 1'b0;
            lvl_q  <= LVL_LOW;
        end else begin
            if (thr_wr) begin
                thr_q <= reg_wdata;
            end else if (fire) begin
                thr_q <= adv.val;
            end

            if (thr_wr) begin
                wait_q <= 1'b0;
            end else if (fire && adv.wrapped) begin
                wait_q <= 1'b1;
            end else if (sec_roll) begin
                wait_q <= 1'b0;
            end

            if (!ctl_q.en) begin
                lvl_q <= LVL_LOW;
            end else if (fire) begin
                lvl_q <= nxt_lvl;
            end
        end
    end

    // R5: compare stays closed after a wrap until the rollover strobe
    p_wait_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.en && wait_q && !sec_roll) |=> $stable(lvl_q));

    // R3: no toggle while the counter is below the threshold
    p_below_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.en && cur_ns < thr_ns) |=> $stable(lvl_q));

    // R3: an open compare with the counter at or past the threshold toggles
    p_fire_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.en && !thr_wr && !wait_q && cur_ns >= thr_ns)
        |=> (lvl_q != $past(lvl_q)));

    // R9: disabled output returns the level to low
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.en |=> (lvl_q == LVL_LOW));

    // R8: threshold write loads the data word
    p_thr_load_r8: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> (thr_q == $past(reg_wdata)));
endmodule

// File: rtl/pps_gen.sv
module pps_gen
    import pps_pkg::*;
#(
    parameter ns_t SEC_NS = 32'd1_000_000_000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic            cfg_en,
    input  logic            cfg_inv,
    input  logic            hi_inc_wr,
    input  logic            lo_inc_wr,
    input  logic            thr_wr,
    input  logic [FX_W-1:0] reg_wdata,
    input  logic [NS_W-1:0] cur_ns,
    input  logic            sec_roll,
    output logic            pps_out
);
    ctl_t            ctl_q;
    fx_t [N_INC-1:0] inc_q;
    lvl_e            lvl_q;
    logic [N_INC-1:0] inc_wr;

    assign inc_wr = {hi_inc_wr, lo_inc_wr};

    pps_ctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_en    (cfg_en),
        .cfg_inv   (cfg_inv),
        .inc_wr    (inc_wr),
        .reg_wdata (reg_wdata),
        .ctl_q     (ctl_q),
        .inc_q     (inc_q)
    );

    pps_edge_sched #(.SEC_NS(SEC_NS)) u_sched (
        .clk       (clk),
        .rst       (rst),
        .ctl_q     (ctl_q),
        .inc_q     (inc_q),
        .thr_wr    (thr_wr),
        .reg_wdata (reg_wdata),
        .cur_ns    (cur_ns),
        .sec_roll  (sec_roll),
        .lvl_q     (lvl_q)
    );

    assign pps_out = ctl_q.en ? ((lvl_q == LVL_HIGH) ^ ctl_q.inv) : ctl_q.inv;

    // R2: a disabled output does not move unless the controls are rewritten
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.en && !cfg_wr) |=> $stable(pps_out));
endmodule

// File: tb/sim_pps_gen.sv
`timescale 1ns/1ps
module sim_pps_gen;
    localparam longint unsigned SEC = 64'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0, cfg_en = 1'b0, cfg_inv = 1'b0;
    logic        hi_inc_wr = 1'b0, lo_inc_wr = 1'b0, thr_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [31:0] cur_ns = '0;
    logic        sec_roll = 1'b0;
    logic        pps_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pps_gen u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_inv(cfg_inv),
        .hi_inc_wr(hi_inc_wr), .lo_inc_wr(lo_inc_wr), .thr_wr(thr_wr),
        .reg_wdata(reg_wdata), .cur_ns(cur_ns), .sec_roll(sec_roll), .pps_out(pps_out)
    );

    // reference state, stepped from the requirements
    longint unsigned m_thr, m_hi, m_lo, m_sum, m_inc;
    bit m_wait, m_lvl, m_en, m_inv, m_fire, m_wrap;

    always @(posedge clk) begin
        if (rst) begin
            m_thr = 0; m_hi = 0; m_lo = 0;
            m_wait = 0; m_lvl = 0; m_en = 0; m_inv = 0;
        end else begin
            m_fire = m_en && !thr_wr && (!m_wait || sec_roll)
                     && (longint'(cur_ns) >= (m_thr >> 32));
            m_inc  = m_lvl ? m_lo : m_hi;
            m_sum  = m_thr + m_inc;
            m_wrap = (m_sum >> 32) >= SEC;
            if (m_wrap) m_sum = m_sum - (SEC << 32);
            if (thr_wr) m_wait = 0;
            else if (m_fire && m_wrap) m_wait = 1;
            else if (sec_roll) m_wait = 0;
            if (thr_wr) m_thr = reg_wdata;
            else if (m_fire) m_thr = m_sum;
            if (!m_en) m_lvl = 0;
            else if (m_fire) m_lvl = ~m_lvl;
            if (cfg_wr) begin m_en = cfg_en; m_inv = cfg_inv; end
            if (hi_inc_wr) m_hi = reg_wdata;
            if (lo_inc_wr) m_lo = reg_wdata;
        end
    end

    function automatic bit exp_out();
        return m_en ? (m_lvl ^ m_inv) : m_inv;
    endfunction

    task automatic check(string tag, bit act, bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: pps_out=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock with the counter advanced by step
    task automatic run(string tag, longint unsigned step);
        longint unsigned nxt;
        nxt = longint'(cur_ns) + step;
        sec_roll = 1'b0;
        if (nxt >= SEC) begin
            nxt = nxt - SEC;
            sec_roll = 1'b1;
        end
        cur_ns = nxt[31:0];
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 0; hi_inc_wr = 0; lo_inc_wr = 0; thr_wr = 0;
        check(tag, pps_out, exp_out());
    endtask

    task automatic wr_cfg(string tag, bit en, bit inv);
        cfg_wr = 1; cfg_en = en; cfg_inv = inv; run(tag, 0);
    endtask
    task automatic wr_hi(string tag, longint unsigned v);
        hi_inc_wr = 1; reg_wdata = v; run(tag, 0);
    endtask
    task automatic wr_lo(string tag, longint unsigned v);
        lo_inc_wr = 1; reg_wdata = v; run(tag, 0);
    endtask
    task automatic wr_thr(string tag, longint unsigned v);
        thr_wr = 1; reg_wdata = v; run(tag, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1", pps_out, 1'b0);

        // R2: disabled with inversion, counter sweeps past threshold
        wr_cfg("R2", 0, 1);
        check("R2", pps_out, 1'b1);
        wr_thr("R2", 64'd100 << 32);
        for (int i = 0; i < 10; i++) run("R2", 500);

        // R8: enable takes effect the cycle after the write
        wr_cfg("R8", 1, 0);
        for (int i = 0; i < 5; i++) run("R8", 10);

        // R3 / R4: fractional intervals
        wr_hi("R4", (64'd300 << 32) | 64'h8000_0000);
        wr_lo("R4", (64'd200 << 32) | 64'h4000_0000);
        cur_ns = 0;
        wr_thr("R3", 64'd1000 << 32);
        for (int i = 0; i < 150; i++) run("R4", 37);

        // R5 / R6: threshold wraps exactly onto the second boundary
        wr_hi("R5", 64'd200 << 32);
        wr_lo("R5", 64'd200 << 32);
        cur_ns = 32'd999_999_000;
        wr_thr("R5", 64'd999_999_800 << 32);
        for (int i = 0; i < 9; i++) run("R5", 100);
        for (int i = 0; i < 30; i++) run("R6", 100);

        // R7: counter far past a chain of 1 ns thresholds
        wr_hi("R7", 64'd1 << 32);
        wr_lo("R7", 64'd1 << 32);
        cur_ns = 32'd5000;
        wr_thr("R7", 64'd0);
        for (int i = 0; i < 20; i++) begin
            bit prev;
            prev = pps_out;
            run("R7", 0);
            check("R7", pps_out, ~prev);
        end

        // R9: disable then re-enable inverted
        wr_cfg("R9", 0, 0);
        check("R9", pps_out, 1'b0);
        wr_cfg("R9", 1, 1);
        check("R9", pps_out, 1'b1);
        run("R9", 0);
        check("R9", pps_out, 1'b0);

        // R10: 1 Hz, 50% duty with 25 ms counter steps
        wr_cfg("R10", 0, 0);
        cur_ns = 0;
        wr_hi("R10", 64'd500_000_000 << 32);
        wr_lo("R10", 64'd500_000_000 << 32);
        wr_thr("R10", 64'd0);
        wr_cfg("R10", 1, 0);
        begin
            int highs;
            highs = 0;
            for (int i = 0; i < 200; i++) begin
                run("R10", 25_000_000);
                if (pps_out) highs++;
            end
            total++;
            if (highs < 99 || highs > 101) begin
                bad++;
                $display("FAIL R10: high cycles=%0d expected=100", highs);
            end
        end

        // constrained random mix (R3, R4, R5, R8)
        for (int i = 0; i < 4000; i++) begin
            int unsigned pick;
            pick = $urandom % 100;
            if (pick < 2) wr_cfg("R8", ($urandom % 8) != 0, $urandom % 2);
            else if (pick < 4) wr_hi("R4", ((64'($urandom % 50_000_000) + 1000) << 32) | 64'($urandom));
            else if (pick < 6) wr_lo("R4", ((64'($urandom % 50_000_000) + 1000) << 32) | 64'($urandom));
            else if (pick < 7) wr_thr("R8", 64'($urandom % 1_000_000_000) << 32);
            else run("R5", 64'($urandom % 400_000) + 1);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule